// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port Block Memory

This block is an 18 Kbit synchronous memory with two ports, A and B, each running on its own clock. A parameter fixes each port's shape as one of six width/depth pairs, and the two ports may differ while sharing the same storage. Byte-based shapes (9, 18 and 36 bits) carry parity bits next to their data and reach the whole 18 Kbit store. Bit-based shapes (1, 2 and 4 bits) reach only the 16 Kbit data part.

Each port has an enable, a write enable, a synchronous clear of its output register, an address, write data, write parity, read data and read parity. Reads and writes take effect on the rising edge of the port's own clock. The read value is held in an output register. When a port writes, that register shows the word as it was before the write.

A word of a wide port overlays a run of narrow-port words. Data bits keep their flat index, so a byte-based port's data area and a bit-based port's whole space line up bit for bit.

Top module: `mixed_aspect_bram`

## Requirements
- R1: Each port width is 1, 2, 4, 9, 18 or 36. The address widths are 14, 13, 12, 11, 10 and 9 bits. Widths 9, 18 and 36 split into 8+1, 16+2 and 32+4 data+parity bits. Narrow widths have a 1-bit parity pin that is unused.
- R2: On a rising edge with enable and write enable both high, the presented data (and parity, on byte-based ports) is stored at the presented address.
- R3: On a rising edge with enable high and clear low, the output register takes the addressed contents. The value is visible after that edge.
- R4: On a write, the writing port's output register takes the contents held before the write (read-first).
- R5: With enable low, the output register holds and no write takes place, whatever the other inputs are.
- R6: On a rising edge with enable and clear high, the output register becomes zero, even if a read is requested. The clear does not change memory contents, and a write requested in the same cycle is still performed.
- R7: Data bit k of the word at address a of a port with data width D is the flat data bit a*D+k. This bit is shared with every other port shape.
- R8: Parity bit j of the word at address a of a byte-based port with parity width P is the flat parity bit a*P+j.
- R9: A bit-based port ignores its parity input, always shows zero on its parity output, and never alters parity bits.
- R10: Each port's output register and writes change only on that port's own rising edge. Activity on the other port leaves them untouched until that edge.
- R11: All memory contents start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge active |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A synchronous output clear |
| addr_a | input | addr_w(PORT_A_WIDTH) | Port A word address |
| din_a | input | data_w(PORT_A_WIDTH) | Port A write data |
| dinp_a | input | pin_w(PORT_A_WIDTH) | Port A write parity |
| dout_a | output | data_w(PORT_A_WIDTH) | Port A registered read data |
| doutp_a | output | pin_w(PORT_A_WIDTH) | Port A registered read parity |
| clk_b | input | 1 | Port B clock, rising edge active |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B synchronous output clear |
| addr_b | input | addr_w(PORT_B_WIDTH) | Port B word address |
| din_b | input | data_w(PORT_B_WIDTH) | Port B write data |
| dinp_b | input | pin_w(PORT_B_WIDTH) | Port B write parity |
| dout_b | output | data_w(PORT_B_WIDTH) | Port B registered read data |
| doutp_b | output | pin_w(PORT_B_WIDTH) | Port B registered read parity |

## Verification
The bench runs an 18-bit port A against a 4-bit port B on two clocks whose rising edges never coincide.

Directed sequences cover several cases:
- A 16-bit word is written on A and read back nibble by nibble on B, which separates a correct flat bit mapping from a reversed or scaled one.
- A narrow write with garbage on the parity pin is read back on A, which shows whether parity is reached from the narrow side.
- Clear, read-first, disabled writes and two adjacent parity slots each have their own case.

Random phases then mix reads, writes and clears on both ports against a behavioural flat-bit model. This catches errors in slot selection, masking, and which bank is updated.

// File: rtl/mab_pkg.sv
package mab_pkg;
  localparam int ROW_DATA = 32;
  localparam int ROW_PAR  = 4;
  localparam int ROW_BITS = ROW_DATA + ROW_PAR;
  localparam int ROWS     = 512;
  localparam int ROW_AW   = $clog2(ROWS);

  typedef logic [ROW_BITS-1:0] row_t;

  function automatic bit legal_w(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  // data bits carried by one word of a port of total width w
  function automatic int data_w(int w);
    case (w)
      9:       return 8;
      18:      return 16;
      36:      return 32;
      default: return w;
    endcase
  endfunction

  function automatic int par_w(int w);
    return w - data_w(w);
  endfunction

  // parity pin width; bit-based ports keep a single unused pin
  function automatic int pin_w(int w);
    return (par_w(w) == 0) ? 1 : par_w(w);
  endfunction

  function automatic int addr_w(int w);
    return $clog2((ROWS * ROW_DATA) / data_w(w));
  endfunction

  // words of this shape that share one storage row
  function automatic int words_per_row(int w);
    return ROW_DATA / data_w(w);
  endfunction

  function automatic int row_of(int w, int a);
    return a / words_per_row(w);
  endfunction

  function automatic int slot_of(int w, int a);
    return a % words_per_row(w);
  endfunction
endpackage

// File: rtl/mab_lane.sv
module mab_lane import mab_pkg::*; #(
  parameter  int WIDTH = 36,
  localparam int DW    = data_w(WIDTH),
  localparam int PW    = par_w(WIDTH),
  localparam int PIW   = pin_w(WIDTH),
  localparam int AW    = addr_w(WIDTH)
) (
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  input  logic [PIW-1:0]    pin,
  input  row_t              row_rd,
  output logic [ROW_AW-1:0] row_idx,
  output row_t              wmask,
  output row_t              wbits,
  output logic [DW-1:0]     rdata,
  output logic [PIW-1:0]    rpar
);
  int   slot;
  int   doff;
  row_t dmask;
  row_t dbits;

  always_comb begin
    row_idx = ROW_AW'(row_of(WIDTH, int'(addr)));
    slot    = slot_of(WIDTH, int'(addr));
    doff    = slot * DW;
    dmask   = row_t'({DW{1'b1}}) << doff;
    dbits   = row_t'(din) << doff;
    rdata   = DW'(row_rd >> doff);
  end

  if (PW > 0) begin : g_par
    int poff;
    always_comb begin
      poff  = ROW_DATA + slot * PW;
      wmask = dmask | (row_t'({PW{1'b1}}) << poff);
      wbits = dbits | (row_t'(pin) << poff);
      rpar  = PIW'(row_rd >> poff);
    end
  end else begin : g_nopar
    logic unused_pin;
    assign unused_pin = ^pin;
    assign wmask      = dmask;
    assign wbits      = dbits;
    assign rpar       = '0;
  end
endmodule

// File: rtl/mab_bank.sv
module mab_bank import mab_pkg::*; (
  input  logic              clk,
  input  logic              wr,
  input  logic [ROW_AW-1:0] own_row,
  input  row_t              wmask,
  input  row_t              wbits,
  input  row_t              peer_at_own,
  input  logic [ROW_AW-1:0] peer_row,
  output row_t              own_at_own,
  output row_t              own_at_peer
);
  row_t mem [ROWS];

  // power-up content: both banks zero, so their XOR reads as zero
  initial begin
    for (int i = 0; i < ROWS; i++) mem[i] = '0;
  end

  assign own_at_own  = mem[own_row];
  assign own_at_peer = mem[peer_row];

  // stored form: value XOR peer bank, so that the XOR of both banks is the value
  row_t enc;
  assign enc = wbits ^ peer_at_own;

  always @(posedge clk) begin
    if (wr) mem[own_row] <= (mem[own_row] & ~wmask) | (enc & wmask);
  end

  // observation points for the checks below
  logic [ROW_AW-1:0] row_q;
  row_t              eff_mask;
  row_t              after_w;
  always_ff @(posedge clk) row_q <= own_row;
  assign eff_mask = wr ? wmask : '0;
  assign after_w  = mem[row_q];

  // R5 / R9: bits outside the active write mask keep their value
  p_keep_unmasked_r5: assert property (@(posedge clk)
    1'b1 |=> ((after_w & ~$past(eff_mask)) == ($past(own_at_own) & ~$past(eff_mask))));

  // R2: masked bits, merged with the peer bank, equal the written value
  p_store_value_r2: assert property (@(posedge clk)
    wr |=> (((after_w ^ $past(peer_at_own)) & $past(wmask)) == ($past(wbits) & $past(wmask))));
endmodule

// File: rtl/mab_outreg.sv
module mab_outreg #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             en,
  input  logic             ssr,
  input  logic [WIDTH-1:0] ld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) q <= ssr ? '0 : ld;
  end

  p_ssr_clears_r6: assert property (@(posedge clk) (en && ssr) |=> (q == '0));
  p_disabled_hold_r5: assert property (@(posedge clk) !en |=> $stable(q));
  p_read_load_r3: assert property (@(posedge clk) (en && !ssr) |=> (q == $past(ld)));
endmodule

// File: rtl/mixed_aspect_bram.sv
module mixed_aspect_bram import mab_pkg::*; #(
  parameter  int PORT_A_WIDTH = 36,
  parameter  int PORT_B_WIDTH = 9,
  localparam int DW_A  = data_w(PORT_A_WIDTH),
  localparam int PIW_A = pin_w(PORT_A_WIDTH),
  localparam int AW_A  = addr_w(PORT_A_WIDTH),
  localparam int DW_B  = data_w(PORT_B_WIDTH),
  localparam int PIW_B = pin_w(PORT_B_WIDTH),
  localparam int AW_B  = addr_w(PORT_B_WIDTH)
) (
  input  logic             clk_a,
  input  logic             en_a,
  input  logic             we_a,
  input  logic             ssr_a,
  input  logic [AW_A-1:0]  addr_a,
  input  logic [DW_A-1:0]  din_a,
  input  logic [PIW_A-1:0] dinp_a,
  output logic [DW_A-1:0]  dout_a,
  output logic [PIW_A-1:0] doutp_a,
  input  logic             clk_b,
  input  logic             en_b,
  input  logic             we_b,
  input  logic             ssr_b,
  input  logic [AW_B-1:0]  addr_b,
  input  logic [DW_B-1:0]  din_b,
  input  logic [PIW_B-1:0] dinp_b,
  output logic [DW_B-1:0]  dout_b,
  output logic [PIW_B-1:0] doutp_b
);
  if (!legal_w(PORT_A_WIDTH) || !legal_w(PORT_B_WIDTH)) begin : g_bad_width
    $error("mixed_aspect_bram: port width must be 1, 2, 4, 9, 18 or 36");
  end

  logic [ROW_AW-1:0] row_a, row_b;
  row_t mask_a, mask_b, bits_a, bits_b;
  row_t a_at_a, a_at_b, b_at_a, b_at_b;
  row_t merged_a, merged_b;
  logic [DW_A-1:0]  rd_a;
  logic [PIW_A-1:0] rp_a;
  logic [DW_B-1:0]  rd_b;
  logic [PIW_B-1:0] rp_b;
  logic             wr_a, wr_b;
  logic [DW_A+PIW_A-1:0] q_a;
  logic [DW_B+PIW_B-1:0] q_b;

  assign wr_a = en_a && we_a;
  assign wr_b = en_b && we_b;

  // stored value = XOR of the two banks at a row
  assign merged_a = a_at_a ^ b_at_a;
  assign merged_b = b_at_b ^ a_at_b;

  mab_lane #(.WIDTH(PORT_A_WIDTH)) u_lane_a (
    .addr(addr_a), .din(din_a), .pin(dinp_a), .row_rd(merged_a),
    .row_idx(row_a), .wmask(mask_a), .wbits(bits_a), .rdata(rd_a), .rpar(rp_a)
  );

  mab_lane #(.WIDTH(PORT_B_WIDTH)) u_lane_b (
    .addr(addr_b), .din(din_b), .pin(dinp_b), .row_rd(merged_b),
    .row_idx(row_b), .wmask(mask_b), .wbits(bits_b), .rdata(rd_b), .rpar(rp_b)
  );

  mab_bank u_bank_a (
    .clk(clk_a), .wr(wr_a), .own_row(row_a), .wmask(mask_a), .wbits(bits_a),
    .peer_at_own(b_at_a), .peer_row(row_b), .own_at_own(a_at_a), .own_at_peer(a_at_b)
  );

  mab_bank u_bank_b (
    .clk(clk_b), .wr(wr_b), .own_row(row_b), .wmask(mask_b), .wbits(bits_b),
    .peer_at_own(a_at_b), .peer_row(row_a), .own_at_own(b_at_b), .own_at_peer(b_at_a)
  );

  mab_outreg #(.WIDTH(DW_A + PIW_A)) u_out_a (
    .clk(clk_a), .en(en_a), .ssr(ssr_a), .ld({rp_a, rd_a}), .q(q_a)
  );

  mab_outreg #(.WIDTH(DW_B + PIW_B)) u_out_b (
    .clk(clk_b), .en(en_b), .ssr(ssr_b), .ld({rp_b, rd_b}), .q(q_b)
  );

  assign dout_a  = q_a[DW_A-1:0];
  assign doutp_a = q_a[DW_A +: PIW_A];
  assign dout_b  = q_b[DW_B-1:0];
  assign doutp_b = q_b[DW_B +: PIW_B];
endmodule

// File: tb/mixed_aspect_bram_bench.sv
module mixed_aspect_bram_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_HALF   = 7;
  localparam int WA  = 18;
  localparam int WB  = 4;
  localparam int DA  = 16;
  localparam int PA  = 2;
  localparam int DB  = 4;
  localparam int AWA = 10;
  localparam int AWB = 12;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic en_a, we_a, ssr_a, en_b, we_b, ssr_b;
  logic [AWA-1:0] addr_a;
  logic [AWB-1:0] addr_b;
  logic [DA-1:0]  din_a, dout_a;
  logic [PA-1:0]  dinp_a, doutp_a;
  logic [DB-1:0]  din_b, dout_b;
  logic [0:0]     dinp_b, doutp_b;

  int n_chk = 0;
  int n_bad = 0;

  mixed_aspect_bram #(.PORT_A_WIDTH(WA), .PORT_B_WIDTH(WB)) u_mixed_aspect_bram (
    .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
    .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
    .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
    .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
  );

  // rising edges: A at 5+10k (odd), B at 8+14k (even) -> never together
  initial forever #(CLK_PERIOD/2) clk_a = ~clk_a;
  initial begin
    #1;
    forever #(CLK_B_HALF) clk_b = ~clk_b;
  end

  // ---------------- behavioural model: flat bit arrays ----------------
  bit [31:0] md [512];
  bit [3:0]  mp [512];

  function automatic bit get_d(int i);
    return md[i / 32][i % 32];
  endfunction
  function automatic bit get_p(int i);
    return mp[i / 4][i % 4];
  endfunction

  function automatic logic [DA+PA-1:0] model_rd_a(int a);
    logic [DA+PA-1:0] v;
    for (int k = 0; k < DA; k++) v[k] = get_d(a * DA + k);
    for (int j = 0; j < PA; j++) v[DA + j] = get_p(a * PA + j);
    return v;
  endfunction

  function automatic logic [DB-1:0] model_rd_b(int a);
    logic [DB-1:0] v;
    for (int k = 0; k < DB; k++) v[k] = get_d(a * DB + k);
    return v;
  endfunction

  task automatic model_wr_a(int a, logic [DA-1:0] d, logic [PA-1:0] p);
    for (int k = 0; k < DA; k++) md[(a * DA + k) / 32][(a * DA + k) % 32] = d[k];
    for (int j = 0; j < PA; j++) mp[(a * PA + j) / 4][(a * PA + j) % 4] = p[j];
  endtask

  task automatic model_wr_b(int a, logic [DB-1:0] d);
    for (int k = 0; k < DB; k++) md[(a * DB + k) / 32][(a * DB + k) % 32] = d[k];
  endtask

  logic [DA+PA-1:0] exp_a;
  logic [DB-1:0]    exp_b;
  bit    kn_a = 1'b0, kn_b = 1'b0;
  string tag_a = "R5", tag_b = "R5";
  bit    ca_q = 1'b0, cb_q = 1'b0;

  always @(clk_a or clk_b) begin
    if (clk_a && !ca_q) begin
      if (en_a) begin
        kn_a = 1'b1;
        if (ssr_a) begin
          exp_a = '0; tag_a = "R6";
        end else begin
          exp_a = model_rd_a(int'(addr_a)); tag_a = we_a ? "R4" : "R3";
        end
        if (we_a) model_wr_a(int'(addr_a), din_a, dinp_a);
      end else tag_a = "R5";
    end
    if (clk_b && !cb_q) begin
      if (en_b) begin
        kn_b = 1'b1;
        if (ssr_b) begin
          exp_b = '0; tag_b = "R6";
        end else begin
          exp_b = model_rd_b(int'(addr_b)); tag_b = we_b ? "R4" : "R3";
        end
        if (we_b) model_wr_b(int'(addr_b), din_b);
      end else tag_b = "R10";
    end
    ca_q = clk_a;
    cb_q = clk_b;
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare on every falling edge of each port's clock
  always @(negedge clk_a) if (kn_a) check(tag_a, 64'({doutp_a, dout_a}), 64'(exp_a));
  // R9: parity output of the narrow port must read zero
  always @(negedge clk_b) if (kn_b) check(tag_b, 64'({doutp_b, dout_b}), 64'({1'b0, exp_b}));

  // ---------------- stimulus ----------------
  task automatic op_a(bit en, bit we, bit ssr, int a, logic [DA-1:0] d, logic [PA-1:0] p);
    @(negedge clk_a);
    en_a = en; we_a = we; ssr_a = ssr; addr_a = AWA'(a); din_a = d; dinp_a = p;
    @(negedge clk_a);
    en_a = 1'b0; we_a = 1'($urandom); ssr_a = 1'($urandom);
    din_a = DA'($urandom); addr_a = AWA'($urandom);
  endtask

  task automatic op_b(bit en, bit we, bit ssr, int a, logic [DB-1:0] d, logic p);
    @(negedge clk_b);
    en_b = en; we_b = we; ssr_b = ssr; addr_b = AWB'(a); din_b = d; dinp_b = p;
    @(negedge clk_b);
    en_b = 1'b0; we_b = 1'($urandom); ssr_b = 1'($urandom);
    din_b = DB'($urandom); addr_b = AWB'($urandom);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    en_a = 0; we_a = 0; ssr_a = 0; addr_a = '0; din_a = '0; dinp_a = '0;
    en_b = 0; we_b = 0; ssr_b = 0; addr_b = '0; din_b = '0; dinp_b = '0;

    // R1: pin widths follow the chosen shapes
    check("R1", 64'($bits(addr_a)), 64'(10));
    check("R1", 64'($bits(dout_a)), 64'(16));
    check("R1", 64'($bits(doutp_a)), 64'(2));
    check("R1", 64'($bits(addr_b)), 64'(12));
    check("R1", 64'($bits(dout_b)), 64'(4));

    // reset state through the clear (R6)
    fork
      op_a(1, 0, 1, 0, '0, '0);
      op_b(1, 0, 1, 0, '0, 1'b0);
    join
    check("R6", 64'({doutp_a, dout_a}), 64'(0));
    check("R6", 64'({doutp_b, dout_b}), 64'(0));

    // R11: untouched content reads zero
    op_a(1, 0, 0, 700, '0, '0);
    check("R11", 64'({doutp_a, dout_a}), 64'(0));
    op_b(1, 0, 0, 100, '0, 1'b0);
    check("R11", 64'(dout_b), 64'(0));

    // R2 write, R3 read
    op_a(1, 1, 0, 3, 16'h1234, 2'b01);
    op_a(1, 0, 0, 3, '0, '0);
    check("R2", 64'({doutp_a, dout_a}), 64'({2'b01, 16'h1234}));

    // R6: clear wins over read and leaves memory alone
    op_a(1, 0, 1, 3, '0, '0);
    check("R6", 64'({doutp_a, dout_a}), 64'(0));
    op_a(1, 0, 0, 3, '0, '0);
    check("R6", 64'({doutp_a, dout_a}), 64'({2'b01, 16'h1234}));

    // R4: read-first on write
    op_a(1, 1, 0, 3, 16'hABCD, 2'b10);
    check("R4", 64'({doutp_a, dout_a}), 64'({2'b01, 16'h1234}));
    op_a(1, 0, 0, 3, '0, '0);
    check("R4", 64'({doutp_a, dout_a}), 64'({2'b10, 16'hABCD}));

    // R7: 16-bit word at address 5 covers nibble addresses 20..23
    op_a(1, 1, 0, 5, 16'hBEEF, 2'b10);
    op_b(1, 0, 0, 20, '0, 1'b0);
    check("R7", 64'(dout_b), 64'(4'hF));
    op_b(1, 0, 0, 21, '0, 1'b0);
    check("R7", 64'(dout_b), 64'(4'hE));
    op_b(1, 0, 0, 23, '0, 1'b0);
    check("R7", 64'(dout_b), 64'(4'hB));

    // R9: narrow write with a set parity pin leaves parity alone
    op_b(1, 1, 0, 21, 4'h3, 1'b1);
    check("R9", 64'(doutp_b), 64'(0));
    op_a(1, 0, 0, 5, '0, '0);
    check("R9", 64'({doutp_a, dout_a}), 64'({2'b10, 16'hBE3F}));

    // R8: neighbouring parity slots within one parity row
    op_a(1, 1, 0, 6, 16'h0000, 2'b01);
    op_a(1, 1, 0, 7, 16'h5555, 2'b11);
    op_a(1, 0, 0, 6, '0, '0);
    check("R8", 64'({doutp_a, dout_a}), 64'({2'b01, 16'h0000}));
    op_a(1, 0, 0, 7, '0, '0);
    check("R8", 64'({doutp_a, dout_a}), 64'({2'b11, 16'h5555}));

    // R5: disabled write neither stores nor moves the output
    op_a(1, 0, 0, 5, '0, '0);
    op_a(0, 1, 0, 5, 16'h0000, 2'b00);
    check("R5", 64'({doutp_a, dout_a}), 64'({2'b10, 16'hBE3F}));
    op_a(1, 0, 0, 5, '0, '0);
    check("R5", 64'({doutp_a, dout_a}), 64'({2'b10, 16'hBE3F}));

    // R10: port B writes do not touch port A's register until A's own edge
    for (int i = 0; i < 4; i++) op_b(1, 1, 0, 20 + i, 4'h7, 1'b0);
    check("R10", 64'({doutp_a, dout_a}), 64'({2'b10, 16'hBE3F}));
    op_a(1, 0, 0, 5, '0, '0);
    check("R10", 64'({doutp_a, dout_a}), 64'({2'b10, 16'h7777}));

    // random traffic on both ports, compared each clock
    fork
      for (int i = 0; i < 800; i++)
        op_a(($urandom % 5) != 0, 1'($urandom), ($urandom % 16) == 0,
             int'($urandom % 1024), DA'($urandom), PA'($urandom));
      for (int i = 0; i < 600; i++)
        op_b(($urandom % 5) != 0, 1'($urandom), ($urandom % 16) == 0,
             int'($urandom % 64), DB'($urandom), 1'($urandom));
    join

    finish_run();
  end
endmodule